// File: doc/BRIEF.md
# Guarded Control Register Write Sequencer

This block sits between a serial bus front end and a small set of nonvolatile control fields: watchdog period select, power-up delay select and array block protection. The front end has already decoded the wire protocol. It hands the block a stream of abstract tokens: start, target select, address, data byte, read and stop. For each select, address, data or read token the block returns one ACK/NACK response.

The nonvolatile fields can change only through a three-transaction sequence:
1. A one-byte write of 02h arms the write-enable latch.
2. A one-byte write of 06h also arms the register-write-enable latch.
3. A third one-byte write carries the new field values.

That third byte starts a commit, modelled as a busy interval of `COMMIT_CYCLES` clocks. The new field values become visible when the busy interval ends.

Writes to the 512-byte memory array are passed to a write strobe port only when the current block-protect setting leaves the address open. A write attempt to a protected address is refused and disarms the register-write-enable latch.

Top module: `ctlreg_write_guard`

The token input is valid/ready, and a token is taken on a cycle with both high. Responses leave on a one-entry valid/ready register. While a response is held and `rsp_ready` is low, `tok_ready` is low, so no token is lost. Control and status pins are plain levels.

Token kinds on `tok_kind` are encoded as follows: 0 start, 1 select, 2 address, 3 data, 4 stop, 5 read. For a select token, `tok_data[0]` = 0 picks the control register and 1 picks the memory array.

A read returns the control image with this layout: bit7 power-up select high bit, bit6..5 watchdog select, bit4..3 block protect, bit2 register-write-enable latch, bit1 write-enable latch, bit0 power-up select low bit.

## Requirements
- R1: After reset, the fields equal `NV_RESET`, both latches are clear, `commit_busy` is low and no response is pending. A read therefore returns the image 00h with the default parameters.
- R2: With the register-write-enable latch clear, a one-byte control write of 02h sets image bit1. A write of 06h while bit1 is set also sets bit2. Neither write raises `commit_busy`.
- R3: With bit2 set, a one-byte payload with bit2 = 0 clears the register-write-enable latch and holds `commit_busy` high for exactly `COMMIT_CYCLES` cycles. When `commit_busy` falls, the fields take the payload values: power-up select = {bit7, bit0}, watchdog select = bit6..5, block protect = bit4..3.
- R4: A payload with bit2 = 1 leaves every field unchanged, leaves bit2 set and starts no busy interval.
- R5: With the register-write-enable latch clear, a control write of any value other than 02h, or of 06h while bit1 is clear, changes nothing.
- R6: In one control transaction, the first data byte is ACKed and every further data byte is NACKed. Such a transaction then has no effect at stop.
- R7: A read token returns the image above with ACK when no commit is busy. Reads between the sequence steps leave the latches and the sequence intact.
- R8: While `commit_busy` is high, a select of the control register is NACKed. The rest of that transaction is NACKed and has no effect.
- R9: Block protect 00 opens the whole array, 01 closes 180h–1FFh, 10 closes 100h–1FFh and 11 closes 000h–1FFh. A data byte to a closed address is NACKed, raises no `mem_we` and clears the register-write-enable latch.
- R10: A data byte to an open address is ACKed and pulses `mem_we` for one cycle with that address and byte. The address then advances by one for the next byte of the same transaction.
- R11: A response whose `rsp_ready` is low stays valid with unchanged `rsp_ack` and `rsp_data`. `tok_ready` stays low until the response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| tok_valid | input | 1 | Token offered |
| tok_ready | output | 1 | Token accepted this cycle when high with tok_valid |
| tok_kind | input | 3 | Token kind (0 start, 1 select, 2 address, 3 data, 4 stop, 5 read) |
| tok_data | input | ADDR_W | Select code, address or data byte (low 8 bits) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_ack | output | 1 | 1 = ACK, 0 = NACK |
| rsp_data | output | 8 | Control image for read responses |
| mem_we | output | 1 | One-cycle array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write byte |
| commit_busy | output | 1 | Nonvolatile commit in progress |
| wd_sel | output | 2 | Current watchdog period select |
| pup_sel | output | 2 | Current power-up delay select |
| bp_sel | output | 2 | Current block-protect setting |

## Verification
The following are checked on every cycle:
- the nonvolatile outputs change only on the cycle the commit busy interval ends;
- the register-write-enable latch is already clear when a busy interval begins;
- a control select during busy is answered with NACK;
- no array write strobe appears under full protection;
- a stalled response holds its value.

Other behaviour can only be shown by the bench's scenarios:
- the exact byte sequences (02h/06h/payload, the cancelling bit 2, the stray values);
- the second-byte abort;
- reads interleaved with the sequence;
- the exact protection boundaries at 17Fh/180h and 0FFh/100h;
- the busy length and the address auto-increment.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

  typedef enum logic [2:0] {
    TK_START  = 3'd0,
    TK_SELECT = 3'd1,
    TK_ADDR   = 3'd2,
    TK_DATA   = 3'd3,
    TK_STOP   = 3'd4,
    TK_READ   = 3'd5
  } tok_kind_t;

  localparam logic TGT_CTL = 1'b0;
  localparam logic TGT_MEM = 1'b1;

  localparam logic [7:0] ARM_WEL  = 8'h02;
  localparam logic [7:0] ARM_BOTH = 8'h06;

  typedef struct packed {
    logic [1:0] pup;
    logic [1:0] wd;
    logic [1:0] bp;
  } nv_t;

  function automatic nv_t payload_fields(input logic [7:0] b);
    nv_t f;
    f.pup = {b[7], b[0]};
    f.wd  = b[6:5];
    f.bp  = b[4:3];
    return f;
  endfunction

  function automatic logic [7:0] ctl_image(input nv_t f, input logic rwel,
                                           input logic wel);
    return {f.pup[1], f.wd, f.bp, rwel, wel, f.pup[0]};
  endfunction

endpackage

// File: rtl/cwg_protect.sv
module cwg_protect #(
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bp,
  output logic              closed
);
  localparam logic [ADDR_W-1:0] QUARTER_BASE = ADDR_W'(3) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] HALF_BASE    = ADDR_W'(1) << (ADDR_W - 1);

  always_comb begin
    unique case (bp)
      2'b00:   closed = 1'b0;
      2'b01:   closed = (addr >= QUARTER_BASE);
      2'b10:   closed = (addr >= HALF_BASE);
      default: closed = 1'b1;
    endcase
  end
endmodule

// File: rtl/cwg_commit_timer.sv
module cwg_commit_timer #(
  parameter int CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;

  logic [CW-1:0] left_q;

  assign done = busy && (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      left_q <= CW'(CYCLES - 1);
    end else if (busy) begin
      if (left_q == '0) busy <= 1'b0;
      else left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/cwg_latch.sv
module cwg_latch
  import cwg_pkg::*;
#(
  parameter logic [5:0] NV_RESET = 6'b000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       apply,
  input  logic [7:0] byte_in,
  input  logic       busy,
  input  logic       done,
  input  logic       prot_clear,
  output logic       wel,
  output logic       rwel,
  output logic       commit_start,
  output nv_t        nv
);
  nv_t pend_q;

  assign commit_start = apply && !busy && rwel && !byte_in[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel    <= 1'b0;
      rwel   <= 1'b0;
      nv     <= nv_t'(NV_RESET);
      pend_q <= nv_t'(NV_RESET);
    end else begin
      if (apply && !busy) begin
        if (rwel) begin
          if (!byte_in[2]) begin
            rwel   <= 1'b0;
            pend_q <= payload_fields(byte_in);
          end
        end else if (byte_in == ARM_WEL) begin
          wel <= 1'b1;
        end else if (byte_in == ARM_BOTH && wel) begin
          rwel <= 1'b1;
        end
      end
      if (prot_clear) rwel <= 1'b0;
      if (done) nv <= pend_q;
    end
  end
endmodule

// File: rtl/ctlreg_write_guard.sv
module ctlreg_write_guard
  import cwg_pkg::*;
#(
  parameter int         ADDR_W        = 9,
  parameter int         COMMIT_CYCLES = 20,
  parameter logic [5:0] NV_RESET      = 6'b000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  output logic              tok_ready,
  input  logic [2:0]        tok_kind,
  input  logic [ADDR_W-1:0] tok_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_ack,
  output logic [7:0]        rsp_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              commit_busy,
  output logic [1:0]        wd_sel,
  output logic [1:0]        pup_sel,
  output logic [1:0]        bp_sel
);
  tok_kind_t         kind;
  logic              fire;
  logic              tgt_q, blk_q;
  logic [1:0]        nbytes_q;
  logic [7:0]        held_q;
  logic [ADDR_W-1:0] addr_q;
  logic              closed, prot_clear, apply;
  logic              wel_q, rwel_q, commit_start, done;
  nv_t               nv;
  logic              want_rsp, ack_n;

  assign kind      = tok_kind_t'(tok_kind);
  assign tok_ready = !rsp_valid || rsp_ready;
  assign fire      = tok_valid && tok_ready;

  cwg_protect #(.ADDR_W(ADDR_W)) u_prot (
    .addr(addr_q), .bp(nv.bp), .closed(closed)
  );

  assign prot_clear = fire && kind == TK_DATA && tgt_q == TGT_MEM && closed;
  assign apply = fire && kind == TK_STOP && tgt_q == TGT_CTL && !blk_q
                 && nbytes_q == 2'd1;

  cwg_latch #(.NV_RESET(NV_RESET)) u_latch (
    .clk(clk), .rst_n(rst_n), .apply(apply), .byte_in(held_q),
    .busy(commit_busy), .done(done), .prot_clear(prot_clear),
    .wel(wel_q), .rwel(rwel_q), .commit_start(commit_start), .nv(nv)
  );

  cwg_commit_timer #(.CYCLES(COMMIT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(commit_start),
    .busy(commit_busy), .done(done)
  );

  assign wd_sel  = nv.wd;
  assign pup_sel = nv.pup;
  assign bp_sel  = nv.bp;

  always_comb begin
    want_rsp = 1'b0;
    ack_n    = 1'b1;
    unique case (kind)
      TK_SELECT: begin
        want_rsp = 1'b1;
        ack_n    = !(tok_data[0] == TGT_CTL && commit_busy);
      end
      TK_ADDR: begin
        want_rsp = 1'b1;
        ack_n    = !blk_q;
      end
      TK_DATA: begin
        want_rsp = 1'b1;
        if (tgt_q == TGT_MEM) ack_n = !closed;
        else ack_n = !blk_q && nbytes_q == 2'd0 && !commit_busy;
      end
      TK_READ: begin
        want_rsp = 1'b1;
        ack_n    = !commit_busy;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q    <= TGT_CTL;
      blk_q    <= 1'b0;
      nbytes_q <= '0;
      held_q   <= '0;
      addr_q   <= '0;
    end else if (fire) begin
      unique case (kind)
        TK_START: begin
          tgt_q    <= TGT_CTL;
          blk_q    <= 1'b0;
          nbytes_q <= '0;
        end
        TK_SELECT: begin
          tgt_q <= tok_data[0];
          blk_q <= (tok_data[0] == TGT_CTL) && commit_busy;
        end
        TK_ADDR: addr_q <= tok_data;
        TK_DATA: begin
          if (tgt_q == TGT_MEM) addr_q <= addr_q + 1'b1;
          else begin
            if (nbytes_q == 2'd0) held_q <= tok_data[7:0];
            if (nbytes_q != 2'd3) nbytes_q <= nbytes_q + 1'b1;
          end
        end
        TK_STOP: begin
          nbytes_q <= '0;
          blk_q    <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      rsp_data  <= '0;
    end else if (fire && want_rsp) begin
      rsp_valid <= 1'b1;
      rsp_ack   <= ack_n;
      rsp_data  <= (kind == TK_READ) ? ctl_image(nv, rwel_q, wel_q) : 8'h00;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= fire && kind == TK_DATA && tgt_q == TGT_MEM && !closed;
      if (fire && kind == TK_DATA && tgt_q == TGT_MEM) begin
        mem_addr  <= addr_q;
        mem_wdata <= tok_data[7:0];
      end
    end
  end
endmodule

// File: rtl/ctlreg_write_guard_chk.sv
module ctlreg_write_guard_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tok_valid,
  input logic              tok_ready,
  input logic [2:0]        tok_kind,
  input logic [ADDR_W-1:0] tok_data,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_ack,
  input logic [7:0]        rsp_data,
  input logic              mem_we,
  input logic              commit_busy,
  input logic [1:0]        wd_sel,
  input logic [1:0]        pup_sel,
  input logic [1:0]        bp_sel,
  input logic              rwel
);
  // R3
  nv_only_at_commit_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({pup_sel, wd_sel, bp_sel}) |-> $fell(commit_busy));

  // R3
  rwel_clear_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commit_busy) |-> !rwel);

  // R8
  busy_select_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_ready && tok_kind == 3'd1 && !tok_data[0] && commit_busy)
    |=> (rsp_valid && !rsp_ack));

  // R9
  full_protect_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(bp_sel) != 2'b11));

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ack) && $stable(rsp_data)));
endmodule

bind ctlreg_write_guard ctlreg_write_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
  .tok_kind(tok_kind), .tok_data(tok_data), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_ack(rsp_ack), .rsp_data(rsp_data),
  .mem_we(mem_we), .commit_busy(commit_busy), .wd_sel(wd_sel),
  .pup_sel(pup_sel), .bp_sel(bp_sel), .rwel(rwel_q)
);

// File: tb/ctlreg_write_guard_tb_top.sv
module ctlreg_write_guard_tb_top;
  localparam int ADDR_W = 9;
  localparam int NCYC   = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tok_valid = 1'b0, rsp_ready = 1'b1;
  logic [2:0] tok_kind = 3'd0;
  logic [ADDR_W-1:0] tok_data = '0;
  logic tok_ready, rsp_valid, rsp_ack, mem_we, commit_busy;
  logic [7:0] rsp_data, mem_wdata;
  logic [ADDR_W-1:0] mem_addr;
  logic [1:0] wd_sel, pup_sel, bp_sel;

  always #10 clk = ~clk;

  ctlreg_write_guard #(.ADDR_W(ADDR_W), .COMMIT_CYCLES(NCYC), .NV_RESET(6'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
    .tok_kind(tok_kind), .tok_data(tok_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_ack(rsp_ack), .rsp_data(rsp_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .commit_busy(commit_busy), .wd_sel(wd_sel), .pup_sel(pup_sel), .bp_sel(bp_sel)
  );

  int checks = 0, failures = 0, we_cnt = 0;
  logic [ADDR_W-1:0] last_addr = '0;
  logic r_valid, r_ack;
  logic [7:0] r_data;
  bit finished = 0;

  always @(negedge clk) if (mem_we) begin we_cnt++; last_addr = mem_addr; end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [ADDR_W-1:0] d);
    @(negedge clk);
    tok_valid = 1'b1; tok_kind = k; tok_data = d;
    @(posedge clk); #1;
    tok_valid = 1'b0;
    @(negedge clk);
    r_valid = rsp_valid; r_ack = rsp_ack; r_data = rsp_data;
  endtask

  task automatic wait_idle();
    while (commit_busy) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [7:0] b, output logic ack);
    send(3'd0, '0); send(3'd1, 9'd0); send(3'd3, {1'b0, b});
    ack = r_ack;
    send(3'd4, '0);
    wait_idle();
  endtask

  task automatic read_img(output logic [7:0] img, output logic ack);
    send(3'd0, '0); send(3'd1, 9'd0); send(3'd5, '0);
    img = r_data; ack = r_ack;
    send(3'd4, '0);
  endtask

  task automatic mem_write(input logic [ADDR_W-1:0] a, input logic [7:0] b, output logic ack);
    send(3'd0, '0); send(3'd1, 9'd1); send(3'd2, a); send(3'd3, {1'b0, b});
    ack = r_ack;
    send(3'd4, '0);
  endtask

  // {control byte, expected image afterwards}
  localparam logic [15:0] VEC [11] = '{
    16'h06_00,  // R5: 06h without WEL ignored
    16'h02_02,  // R2: WEL
    16'h06_06,  // R2: RWEL
    16'h7B_7B,  // R3: commit
    16'h02_7B,  // R2: WEL already set
    16'h06_7F,  // R2
    16'h06_7F,  // R4: bit2 set cancels
    16'h02_02,  // R3: 02,06,02 clears fields
    16'hA3_02,  // R5: stray value
    16'h06_06,  // R2
    16'hB2_B2   // R3
  };

  initial begin
    logic [7:0] img;
    logic ack;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", commit_busy, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    read_img(img, ack);
    check("R1 image", img, 8'h00);
    check("R7 read ack", ack, 1);

    for (int i = 0; i < 11; i++) begin
      ctl_write(VEC[i][15:8], ack);
      read_img(img, ack);
      check($sformatf("R2 R3 R4 R5 vector %0d", i), img, VEC[i][7:0]);
    end
    check("R3 fields", {pup_sel, wd_sel, bp_sel}, 6'b10_01_10);

    // R10 open writes and increment under bp=10
    send(3'd0, '0); send(3'd1, 9'd1); send(3'd2, 9'h0FE);
    send(3'd3, 9'h0AA); check("R10 ack first", r_ack, 1);
    send(3'd3, 9'h055); check("R10 ack second", r_ack, 1);
    send(3'd4, '0);
    check("R10 strobes", we_cnt, 2);
    check("R10 incremented addr", last_addr, 9'h0FF);
    mem_write(9'h100, 8'h11, ack);
    check("R9 bp10 100h nack", ack, 0);
    check("R9 bp10 no strobe", we_cnt, 2);

    // R9 protected attempt clears RWEL
    ctl_write(8'h06, ack);
    read_img(img, ack); check("R2 rwel armed", img, 8'hB6);
    mem_write(9'h1FF, 8'h22, ack);
    check("R9 1FFh nack", ack, 0);
    read_img(img, ack); check("R9 rwel cleared", img, 8'hB2);

    // R6 second byte aborts
    send(3'd0, '0); send(3'd1, 9'd0);
    send(3'd3, 9'h006); check("R6 first ack", r_ack, 1);
    send(3'd3, 9'h002); check("R6 second nack", r_ack, 0);
    send(3'd4, '0);
    check("R6 no busy", commit_busy, 0);
    read_img(img, ack); check("R6 unchanged", img, 8'hB2);

    // R7 reads between steps, R3 busy length
    ctl_write(8'h06, ack);
    read_img(img, ack); check("R7 mid read", img, 8'hB6);
    read_img(img, ack); check("R7 second read", img, 8'hB6);
    send(3'd0, '0); send(3'd1, 9'd0); send(3'd3, 9'h00B); send(3'd4, '0);
    n = 0;
    while (commit_busy && n < 1000) begin n++; @(negedge clk); end
    check("R3 busy length", n, NCYC);
    read_img(img, ack); check("R3 image after commit", img, 8'h0B);

    // R9/R10 boundary under bp=01
    we_cnt = 0;
    send(3'd0, '0); send(3'd1, 9'd1); send(3'd2, 9'h17F);
    send(3'd3, 9'h033); check("R10 17Fh ack", r_ack, 1);
    send(3'd3, 9'h044); check("R9 180h nack", r_ack, 0);
    send(3'd4, '0);
    check("R9 one strobe", we_cnt, 1);
    check("R10 strobe addr", last_addr, 9'h17F);

    // R8 busy blocks control transaction
    ctl_write(8'h06, ack);
    send(3'd0, '0); send(3'd1, 9'd0); send(3'd3, 9'h003); send(3'd4, '0);
    check("R3 busy started", commit_busy, 1);
    send(3'd0, '0);
    send(3'd1, 9'd0); check("R8 select nack", r_ack, 0);
    send(3'd5, '0); check("R7 read nack busy", r_ack, 0);
    send(3'd3, 9'h006); check("R8 data nack", r_ack, 0);
    send(3'd4, '0);
    wait_idle();
    read_img(img, ack); check("R8 no effect", img, 8'h03);

    // bp=00 opens all
    mem_write(9'h1FF, 8'h77, ack); check("R9 bp00 open", ack, 1);
    // bp=11 closes all
    ctl_write(8'h06, ack); ctl_write(8'h1B, ack);
    check("R3 bp11", bp_sel, 2'b11);
    mem_write(9'h000, 8'h01, ack); check("R9 bp11 000h nack", ack, 0);

    // R11 back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    tok_valid = 1'b1; tok_kind = 3'd0; tok_data = '0;
    @(posedge clk); #1; tok_kind = 3'd1; tok_data = 9'd0;
    @(posedge clk); #1; tok_valid = 1'b0;
    @(negedge clk);
    check("R11 held valid", rsp_valid, 1);
    check("R11 ready low", tok_ready, 0);
    @(negedge clk);
    check("R11 still held", {rsp_valid, rsp_ack}, 2'b11);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R11 released", rsp_valid, 0);
    send(3'd4, '0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule